// File: doc/BRIEF.md
# Pipelined Shift-Add Multiplier

The block multiplies two unsigned operands of width `W` and produces their full `2W`-bit product. It works one operand bit per pipeline stage. Stage `i` takes the running sum from the stage before it. When bit `i` of operand `a` is set, the stage adds operand `b` shifted left by `i`. The stage then registers the new sum. The first stage starts from zero. After `W` stages the last register holds the complete product.

Copies of both operands are registered stage by stage next to the running sum. Each stage therefore sees the operand pair that belongs to its own partial sum. A new pair can be presented on every clock cycle. A valid bit travels through the same stages, so each result leaves with its own qualifier. Results come out in the order in which the pairs went in.

Top module: `shift_add_mul`

## Requirements
- R1: When `valid_o` is high, `product_o` equals the unsigned product `a_i * b_i` of the matching input pair, zero-extended to `2W` bits, with no high-order bits lost.
- R2: A pair sampled with `valid_i` high at a rising clock edge appears on `product_o`, with `valid_o` high, right after the `W`-th rising edge counted from and including that edge.
- R3: Pairs presented on consecutive cycles are all accepted, one per cycle, and each returns exactly once. They return on consecutive cycles and in their input order.
- R4: A cycle with `valid_i` low produces a cycle with `valid_o` low exactly `W` edges later. Gaps in the input stream therefore reappear unchanged at the output.
- R5: While `rst_ni` is low, `valid_o` is low. Pairs already in the pipeline when reset is asserted are discarded. After reset is released, `valid_o` stays low until `W` edges after the next valid input.
- R6: A zero operand on either side gives a product of zero. Two all-ones operands give `(2^W-1)^2`, and no product ever exceeds that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all valid bits |
| valid_i | input | 1 | The operand pair on `a_i`/`b_i` is to be multiplied |
| a_i | input | W | Multiplier operand; bit `i` gates stage `i` |
| b_i | input | W | Multiplicand operand, shifted per stage |
| valid_o | output | 1 | `product_o` carries a result |
| product_o | output | 2W | Unsigned product |

## Verification
Some properties are checked on every cycle. Each stage's running sum stays below `2^(W+i+1)`. A stage never changes sum bits below its own shift. The number of pairs in flight never exceeds `W`, and no valid output appears without a matching input. Every product stays at or below the all-ones square, and the output is quiet during reset. The exact latency, the correctness of each product, the ordering of a back-to-back stream, the keeping of bubbles and the flushing by reset in mid-stream can only be shown by the bench scenarios. These compare the outputs against an independently computed product stream.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Bit span a running sum may occupy after stage idx (rows 0..idx added).
  function automatic int unsigned row_span(int unsigned w, int unsigned idx);
    return w + idx + 1;
  endfunction
endpackage

// File: rtl/smul_row.sv
module smul_row #(
  parameter int unsigned W   = 8,
  parameter int unsigned IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [2*W-1:0]   sum_i,
  output logic             vld_o,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     b_o,
  output logic [2*W-1:0]   sum_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] addend;

  always_comb begin
    addend = '0;
    if (a_i[IDX]) addend = {{W{1'b0}}, b_i} << IDX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  // data path is not reset; valid qualifies it
  always_ff @(posedge clk_i) begin
    a_o   <= a_i;
    b_o   <= b_i;
    sum_o <= sum_i + addend;
  end

  generate
    if (IDX > 0) begin : g_low_chk
      // R1
      low_bits_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> sum_o[IDX-1:0] == $past(sum_i[IDX-1:0]));
    end
    if (IDX < W - 1) begin : g_span_chk
      // R1
      row_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> (sum_o >> smul_pkg::row_span(W, IDX)) == '0);
    end
  endgenerate
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic             valid_o,
  output logic [2*W-1:0]   product_o
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned CW = $clog2(W + 1) + 1;
  localparam logic [PW-1:0] OP_MAX   = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [PW-1:0] PROD_MAX = OP_MAX * OP_MAX;

  logic          v_c [W+1];
  logic [W-1:0]  a_c [W+1];
  logic [W-1:0]  b_c [W+1];
  logic [PW-1:0] s_c [W+1];

  assign v_c[0] = valid_i;
  assign a_c[0] = a_i;
  assign b_c[0] = b_i;
  assign s_c[0] = '0;

  generate
    for (genvar g = 0; g < W; g++) begin : g_row
      smul_row #(.W(W), .IDX(g)) u_row (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .vld_i (v_c[g]),
        .a_i   (a_c[g]),
        .b_i   (b_c[g]),
        .sum_i (s_c[g]),
        .vld_o (v_c[g+1]),
        .a_o   (a_c[g+1]),
        .b_o   (b_c[g+1]),
        .sum_o (s_c[g+1])
      );
    end
  endgenerate

  assign valid_o   = v_c[W];
  assign product_o = s_c[W];

  // operand copies leaving the last row are not needed
  logic unused_tail;
  assign unused_tail = ^{a_c[W], b_c[W]};

  // in-flight bookkeeping for the checks below
  logic [CW-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CW'(valid_i) - CW'(valid_o);
  end

  // R3
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(W));

  // R2
  no_orphan_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> inflight_q != '0);

  // R6
  prod_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> product_o <= PROD_MAX);

  // R5
  always_comb begin
    if (!rst_ni) reset_quiet_chk: assert (!valid_o);
  end
endmodule

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned W  = 8;
  localparam int unsigned PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic          valid_o;
  logic [PW-1:0] product_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  string       cur_tag = "R5";
  logic        mon_en = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  shift_add_mul #(.W(W)) i_shift_add_mul (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .valid_i  (valid_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .valid_o  (valid_o),
    .product_o(product_o)
  );

  // expected stream: W-deep delay of (valid, a*b), cleared by reset (R2, R5)
  logic          exp_v [W];
  logic [PW-1:0] exp_p [W];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < W; k++) exp_v[k] <= 1'b0;
    end else begin
      exp_v[0] <= valid_i;
      exp_p[0] <= PW'(a_i) * PW'(b_i);
      for (int k = 1; k < W; k++) begin
        exp_v[k] <= exp_v[k-1];
        exp_p[k] <= exp_p[k-1];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle monitor
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      chk(valid_o === exp_v[W-1], cur_tag, PW'(valid_o), PW'(exp_v[W-1]));
      if (exp_v[W-1]) chk(product_o === exp_p[W-1], cur_tag, product_o, exp_p[W-1]);
    end
  end

  task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    valid_i = v;
    a_i = a;
    b_i = b;
  endtask

  task automatic drain();
    drive(1'b0, '0, '0);
    repeat (W + 2) @(negedge clk);
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic t_reset();
    cur_tag = "R5";
    #1;
    chk(valid_o === 1'b0, "R5 in reset", PW'(valid_o), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (W + 2) begin
      @(negedge clk);
      chk(valid_o === 1'b0, "R5 after release", PW'(valid_o), '0);
    end
    mon_en = 1'b1;
  endtask

  task automatic t_single();
    int lat = 0;
    cur_tag = "R1";
    drive(1'b1, 8'd13, 8'd11);
    drive(1'b0, 8'd0, 8'd0);
    lat = 1;
    while (valid_o !== 1'b1 && lat < 3 * W) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == W, "R2 latency", PW'(lat), PW'(W));
    chk(product_o === PW'(143), "R1 13*11", product_o, PW'(143));
    drain();
  endtask

  task automatic t_corners();
    cur_tag = "R6";
    drive(1'b1, 8'h00, 8'hA5);
    drive(1'b1, 8'h5A, 8'h00);
    drive(1'b1, 8'hFF, 8'hFF);
    drive(1'b1, 8'h01, 8'hFF);
    drive(1'b1, 8'hFF, 8'h01);
    drive(1'b1, 8'h80, 8'h80);
    drain();
  endtask

  task automatic t_stream();
    cur_tag = "R3";
    for (int n = 0; n < 60; n++) begin
      seed = step(seed);
      drive(1'b1, seed[23:16], seed[15:8]);
    end
    drain();
  endtask

  task automatic t_bubbles();
    cur_tag = "R4";
    for (int n = 0; n < 40; n++) begin
      seed = step(seed);
      drive(seed[30] | (n % 3 == 0), seed[23:16], seed[7:0]);
    end
    drain();
  endtask

  task automatic t_mid_reset();
    cur_tag = "R5";
    for (int n = 0; n < W / 2 + 1; n++) drive(1'b1, 8'(n + 3), 8'hC3);
    @(negedge clk);
    valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(valid_o === 1'b0, "R5 flush", PW'(valid_o), '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (W + 2) begin
      @(negedge clk);
      chk(valid_o === 1'b0, "R5 stale pair", PW'(valid_o), '0);
    end
    drive(1'b1, 8'd200, 8'd201);
    drain();
  endtask

  initial begin
    t_reset();
    t_single();
    t_corners();
    t_stream();
    t_bubbles();
    t_mid_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule